// File: doc/BRIEF.md
# Transmit Descriptor DMA Engine

This block moves outgoing frames from system memory to a byte-wide stream. Software builds a linked ring of four-word transmit descriptors in memory. Each descriptor holds a buffer pointer with an ownership flag, a length/status word and a link to the next descriptor. Software then loads the address of the first descriptor into the engine and pulses `start`.

The engine reads the descriptor and checks that it owns it. It reads the frame length, then fetches the frame one byte at a time and presents each byte on the stream port. Once the last byte has been accepted, it writes a completion status over the length word. It then hands the descriptor back by clearing the ownership flag and follows the link. It keeps walking the ring until it meets a descriptor it does not own, then goes idle. A frame longer than the downstream frame store can hold is left untouched, and the engine stops on it. A sticky interrupt flag can be raised for each completed descriptor.

Top module: `tx_desc_dma`

## Requirements
- R1: `ptr_load` while the engine is idle copies `ptr_in` into the current-descriptor pointer, visible on `cur_ptr` one cycle later. While a walk is in progress `ptr_load` is ignored.
- R2: A `start` pulse makes the engine read the 32-bit word at `cur_ptr`. Bit 31 is the ownership flag, 1 meaning the engine owns the descriptor. If it is 0, the engine makes no further memory access and streams nothing.
- R3: The frame length is bits 15:0 of the word at `cur_ptr`+8, and the upper bits are ignored. A length greater than `MAX_BYTES` (default 64) ends the walk after that read: no byte is streamed, nothing is written, and `cur_ptr` keeps its value.
- R4: The buffer address is the first descriptor word with bit 31 cleared. Frame bytes are fetched by byte reads (`mem_byte`=1, byte returned in `mem_rdata[7:0]`) at ascending addresses from the buffer address. They appear on `tx_data` in that order, with `tx_last` high on the final byte only.
- R5: After the final byte is accepted, the engine writes the word at `cur_ptr`+8. The written value has the length in bits 15:0, a 1 in bit 16 and zeros above.
- R6: After the status write completes, the engine writes the buffer address with bit 31 cleared to the word at `cur_ptr`. The status write always precedes the ownership write.
- R7: The engine then reads the word at `cur_ptr`+12, loads it into `cur_ptr`, and continues with that descriptor.
- R8: A descriptor with length 0 streams no bytes but still gets its status and ownership writes and its link is followed.
- R9: `irq` is set one cycle after a descriptor's link read completes if `irq_en` is high in that cycle. It stays set until `irq_clr` is pulsed; a set in the same cycle wins over the clear.
- R10: A memory request (`mem_req`) keeps its address, direction, size and write data stable until it is accepted in a cycle where `mem_ready` is high.
- R11: A stream byte (`tx_valid`) keeps `tx_data` and `tx_last` stable until accepted in a cycle where `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that starts a ring walk at `cur_ptr` |
| ptr_load | input | 1 | Load strobe for the current-descriptor pointer |
| ptr_in | input | AW | Value loaded into the pointer |
| irq_en | input | 1 | Completion interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear for `irq` |
| irq | output | 1 | Sticky completion interrupt |
| cur_ptr | output | AW | Current-descriptor pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_byte | output | 1 | 1 = byte access, 0 = 32-bit word access |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid while `mem_ready` is high |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
Most internal faults in this engine show up in memory within a single descriptor. A wrong length register gives a status word with the wrong low half and a shifted `tx_last`. A stale buffer base makes the byte-read addresses disagree with the expected ascending run. A bad pointer update leaves `cur_ptr` at the wrong place once the walk ends, or sends the engine into descriptors it was never given. Ordering or ownership mistakes are visible after the walk as descriptors still flagged as owned, or with status missing. Interrupt gating faults show on `irq` one cycle after the link read.

// File: rtl/txd_pkg.sv
`timescale 1ns/1ps
package txd_pkg;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 16;
  localparam int OWN_POS  = 31;
  localparam int OFS_STAT = 8;
  localparam int OFS_LINK = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HEAD, ST_SIZE, ST_FETCH, ST_EMIT, ST_STAT, ST_GIVE, ST_LINK
  } txd_state_e;

  function automatic logic owned_by_engine(input logic [WORD_W-1:0] w);
    return w[OWN_POS];
  endfunction

  function automatic logic [WORD_W-1:0] drop_owner(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    r[OWN_POS] = 1'b0;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] done_status(input logic [LEN_W-1:0] len);
    return {{(WORD_W-LEN_W-1){1'b0}}, 1'b1, len};
  endfunction

  function automatic logic too_long(input logic [LEN_W-1:0] len, input int unsigned cap);
    return 32'(len) > cap;
  endfunction
endpackage

// File: rtl/txd_byte_ctr.sv
`timescale 1ns/1ps
module txd_byte_ctr #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [LW-1:0] total,
  output logic [LW-1:0] idx,
  output logic          at_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (clr)   idx <= '0;
    else if (step)  idx <= idx + LW'(1);
  end

  assign at_end = (idx + LW'(1)) == total;
endmodule

// File: rtl/txd_irq_flag.sv
`timescale 1ns/1ps
module txd_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (set)  flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/tx_desc_dma.sv
`timescale 1ns/1ps
module tx_desc_dma
  import txd_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int unsigned MAX_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ptr_load,
  input  logic [AW-1:0]     ptr_in,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic              irq,
  output logic [AW-1:0]     cur_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_byte,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              tx_last,
  input  logic              tx_ready
);
  localparam logic [AW-1:0] STAT_OFS = AW'(OFS_STAT);
  localparam logic [AW-1:0] LINK_OFS = AW'(OFS_LINK);

  txd_state_e        state;
  logic [AW-1:0]     cur_q;
  logic [WORD_W-1:0] buf_q;
  logic [LEN_W-1:0]  len_q;
  logic [7:0]        byte_q;
  logic [LEN_W-1:0]  idx;
  logic              at_end;

  // named events, observed by the bound checker
  logic mem_fire, tx_fire, size_fire, skip_evt, stat_fire, give_fire, frame_done;

  assign mem_fire   = mem_req & mem_ready;
  assign tx_fire    = tx_valid & tx_ready;
  assign size_fire  = (state == ST_SIZE) & mem_fire;
  assign skip_evt   = size_fire & too_long(mem_rdata[LEN_W-1:0], MAX_BYTES);
  assign stat_fire  = (state == ST_STAT) & mem_fire;
  assign give_fire  = (state == ST_GIVE) & mem_fire;
  assign frame_done = (state == ST_LINK) & mem_fire;

  txd_byte_ctr #(.LW(LEN_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (size_fire),
    .step   (tx_fire & ~at_end),
    .total  (len_q),
    .idx    (idx),
    .at_end (at_end)
  );

  txd_irq_flag u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (frame_done & irq_en),
    .clr   (irq_clr),
    .flag  (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cur_q  <= '0;
      buf_q  <= '0;
      len_q  <= '0;
      byte_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ptr_load) cur_q <= ptr_in;
          if (start)    state <= ST_HEAD;
        end
        ST_HEAD: if (mem_fire) begin
          buf_q <= drop_owner(mem_rdata);
          state <= owned_by_engine(mem_rdata) ? ST_SIZE : ST_IDLE;
        end
        ST_SIZE: if (mem_fire) begin
          len_q <= mem_rdata[LEN_W-1:0];
          if (skip_evt)                          state <= ST_IDLE;
          else if (mem_rdata[LEN_W-1:0] == '0)   state <= ST_STAT;
          else                                   state <= ST_FETCH;
        end
        ST_FETCH: if (mem_fire) begin
          byte_q <= mem_rdata[7:0];
          state  <= ST_EMIT;
        end
        ST_EMIT: if (tx_fire) state <= at_end ? ST_STAT : ST_FETCH;
        ST_STAT: if (mem_fire) state <= ST_GIVE;
        ST_GIVE: if (mem_fire) state <= ST_LINK;
        ST_LINK: if (mem_fire) begin
          cur_q <= mem_rdata[AW-1:0];
          state <= ST_HEAD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_byte  = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_HEAD:  begin mem_req = 1'b1; mem_addr = cur_q; end
      ST_SIZE:  begin mem_req = 1'b1; mem_addr = cur_q + STAT_OFS; end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_byte = 1'b1;
        mem_addr = buf_q[AW-1:0] + AW'(idx);
      end
      ST_STAT:  begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_q + STAT_OFS;
        mem_wdata = done_status(len_q);
      end
      ST_GIVE:  begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_q;
        mem_wdata = buf_q;
      end
      ST_LINK:  begin mem_req = 1'b1; mem_addr = cur_q + LINK_OFS; end
      default:  ;
    endcase
  end

  assign cur_ptr  = cur_q;
  assign tx_data  = byte_q;
  assign tx_valid = (state == ST_EMIT);
  assign tx_last  = (state == ST_EMIT) & at_end;
endmodule

// File: rtl/txd_checker.sv
`timescale 1ns/1ps
module txd_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic          mem_byte,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          irq,
  input logic          irq_en,
  input logic          irq_clr,
  input logic          stat_fire,
  input logic          give_fire,
  input logic          skip_evt,
  input logic          frame_done
);
  logic stat_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stat_pending <= 1'b0;
    else if (stat_fire) stat_pending <= 1'b1;
    else if (give_fire) stat_pending <= 1'b0;
  end

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_byte) && $stable(mem_wdata));

  a_r11_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  a_r6_status_first: assert property (@(posedge clk) disable iff (!rst_n)
    give_fire |-> stat_pending);

  a_r6_owner_clear: assert property (@(posedge clk) disable iff (!rst_n)
    give_fire |-> mem_we && !mem_wdata[31]);

  a_r5_status_flag: assert property (@(posedge clk) disable iff (!rst_n)
    stat_fire |-> mem_we && !mem_byte && mem_wdata[31:16] == 16'h0001);

  a_r3_skip_stops: assert property (@(posedge clk) disable iff (!rst_n)
    skip_evt |=> !mem_req && !tx_valid);

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(frame_done && irq_en));

  a_r4_no_stream_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !tx_valid);
endmodule

bind tx_desc_dma txd_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_byte   (mem_byte),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .tx_last    (tx_last),
  .irq        (irq),
  .irq_en     (irq_en),
  .irq_clr    (irq_clr),
  .stat_fire  (stat_fire),
  .give_fire  (give_fire),
  .skip_evt   (skip_evt),
  .frame_done (frame_done)
);

// File: tb/sim_tx_desc_dma.sv
`timescale 1ns/1ps
module sim_tx_desc_dma;
  localparam int AW   = 32;
  localparam int MAXB = 64;
  localparam int MSZ  = 4096;
  localparam int DB   = 'h040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start = 0, ptr_load = 0, irq_en = 0, irq_clr = 0;
  logic [AW-1:0] ptr_in = '0;
  logic          irq, mem_req, mem_we, mem_byte, tx_valid, tx_last;
  logic [AW-1:0] cur_ptr, mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [7:0]    tx_data;
  logic          mem_ready = 0, tx_ready = 0;

  tx_desc_dma #(.AW(AW), .MAX_BYTES(MAXB)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ptr_load(ptr_load), .ptr_in(ptr_in),
    .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq), .cur_ptr(cur_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  logic [7:0]  mem [0:MSZ-1];
  logic [11:0] ma;
  assign ma = mem_addr[11:0];
  assign mem_rdata = mem_byte ? {24'h0, mem[ma]}
                              : {mem[ma+12'd3], mem[ma+12'd2], mem[ma+12'd1], mem[ma]};

  int n_chk = 0, n_fail = 0, xfer_cnt = 0, hold_err = 0, cyc = 0;
  logic [7:0]  rx_q[$];
  bit          rxl_q[$];
  logic [31:0] brd_q[$];
  logic [7:0]  exp_q[$];
  bit          expl_q[$];
  logic [31:0] expa_q[$];
  int          d_addr[8], b_addr[8], d_len[8], link[8];

  // memory and sink model: ready chosen at negedge, transfer logged if it will complete
  bit pend_req = 0, pend_tx = 0;
  logic [AW-1:0] pend_addr = '0;
  logic [7:0]    pend_dat = '0;
  always @(negedge clk) begin
    if (pend_req && (!mem_req || mem_addr != pend_addr)) hold_err++;
    if (pend_tx && (!tx_valid || tx_data != pend_dat)) hold_err++;
    mem_ready = ($urandom % 3) != 0;
    tx_ready  = ($urandom % 4) != 0;
    if (mem_req && mem_ready) begin
      xfer_cnt++;
      if (mem_we) begin
        for (int k = 0; k < 4; k++) mem[ma + 12'(k)] = mem_wdata[8*k +: 8];
      end else if (mem_byte) brd_q.push_back(mem_addr);
    end
    if (tx_valid && tx_ready) begin
      rx_q.push_back(tx_data);
      rxl_q.push_back(tx_last);
    end
    pend_req  = mem_req && !mem_ready;
    pend_addr = mem_addr;
    pend_tx   = tx_valid && !tx_ready;
    pend_dat  = tx_data;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      summary();
    end
  end

  task automatic chkv(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdw(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic wrw(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[a+k] = v[8*k +: 8];
  endtask

  // expected status word restated from R5: bit 16 flag over the length
  function automatic logic [31:0] exp_status(input int len);
    return (32'd1 << 16) | 32'(len & 'hffff);
  endfunction

  task automatic load_ptr(input int p);
    @(negedge clk); ptr_load = 1; ptr_in = AW'(p);
    @(negedge clk); ptr_load = 0;
  endtask

  task automatic run_walk(input bit poke);
    int quiet;
    xfer_cnt = 0; hold_err = 0;
    rx_q.delete(); rxl_q.delete(); brd_q.delete();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    quiet = 0;
    for (int c = 0; quiet < 12; c++) begin
      ptr_load = poke && (c == 4);
      ptr_in   = 32'h0000_0abc;
      @(negedge clk);
      quiet = (mem_req || tx_valid) ? 0 : quiet + 1;
    end
    ptr_load = 0;
  endtask

  task automatic build_ring(input int n, input int zidx, input int l0);
    exp_q.delete(); expl_q.delete(); expa_q.delete();
    for (int i = 0; i < n; i++) begin
      d_addr[i] = DB + 16*i;
      b_addr[i] = 'h200 + 80*i + int'($urandom % 4);
      if (i == zidx)              d_len[i] = 0;
      else if (i == 0 && l0 >= 0) d_len[i] = l0;
      else                        d_len[i] = 1 + int'($urandom % MAXB);
    end
    for (int i = 0; i < n; i++) begin
      link[i] = d_addr[(i+1) % n];
      wrw(d_addr[i], 32'h8000_0000 | 32'(b_addr[i]));
      wrw(d_addr[i] + 8, {16'($urandom), 16'(d_len[i])});
      wrw(d_addr[i] + 12, 32'(link[i]));
      for (int j = 0; j < d_len[i]; j++) begin
        mem[b_addr[i] + j] = 8'($urandom);
        exp_q.push_back(mem[b_addr[i] + j]);
        expl_q.push_back(j == d_len[i] - 1);
        expa_q.push_back(32'(b_addr[i] + j));
      end
    end
    load_ptr(d_addr[0]);
  endtask

  task automatic verify_ring(input int n, input bit irq_exp);
    for (int i = 0; i < n; i++) begin
      chkv("R6 ownership returned, buffer address kept", rdw(d_addr[i]), 32'(b_addr[i]));
      chkv("R5 status word", rdw(d_addr[i] + 8), exp_status(d_len[i]));
      chkv("R7 link word untouched", rdw(d_addr[i] + 12), 32'(link[i]));
    end
    chkv("R7 cur_ptr follows links around ring", cur_ptr, 32'(d_addr[0]));
    chkv("R4 streamed byte count", 32'(rx_q.size()), 32'(exp_q.size()));
    chkv("R4 byte read count", 32'(brd_q.size()), 32'(expa_q.size()));
    if (rx_q.size() == exp_q.size())
      for (int k = 0; k < exp_q.size(); k++) begin
        chkv("R4 byte data in order", 32'(rx_q[k]), 32'(exp_q[k]));
        chkv("R4 tx_last on final byte only", 32'(rxl_q[k]), 32'(expl_q[k]));
      end
    if (brd_q.size() == expa_q.size())
      for (int k = 0; k < expa_q.size(); k++)
        chkv("R4 ascending byte addresses", brd_q[k], expa_q[k]);
    chkv("R9 irq after walk", 32'(irq), 32'(irq_exp));
    chkv("R10 R11 handshake hold", 32'(hold_err), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd7351));
    for (int a = 0; a < MSZ; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    chkv("reset irq", 32'(irq), 0);
    chkv("reset mem_req", 32'(mem_req), 0);
    chkv("reset tx_valid", 32'(tx_valid), 0);
    chkv("reset cur_ptr", cur_ptr, 0);
    rst_n = 1;

    // R1: pointer load while idle
    load_ptr('h123);
    chkv("R1 pointer load while idle", cur_ptr, 32'h123);

    // R2: descriptor not owned by engine
    irq_en = 1;
    wrw('h600, 32'h0000_0700);
    wrw('h608, 32'h0000_0005);
    load_ptr('h600);
    run_walk(0);
    chkv("R2 single access when not owned", 32'(xfer_cnt), 1);
    chkv("R2 no bytes when not owned", 32'(rx_q.size()), 0);
    chkv("R2 descriptor untouched", rdw('h608), 32'h0000_0005);
    chkv("R2 cur_ptr unchanged", cur_ptr, 32'h600);
    chkv("R9 no irq without completion", 32'(irq), 0);

    // R3: frame over capacity, upper bits of length word set
    wrw('h610, 32'h8000_0700);
    wrw('h618, 32'hbeef_0000 | 32'(MAXB + 1));
    wrw('h61c, 32'h0000_0610);
    load_ptr('h610);
    run_walk(0);
    chkv("R3 oversize: two reads then stop", 32'(xfer_cnt), 2);
    chkv("R3 oversize: no bytes", 32'(rx_q.size()), 0);
    chkv("R3 oversize: owner kept", rdw('h610), 32'h8000_0700);
    chkv("R3 oversize: length word kept", rdw('h618), 32'hbeef_0000 | 32'(MAXB + 1));
    chkv("R3 oversize: cur_ptr unchanged", cur_ptr, 32'h610);
    chkv("R9 oversize gives no irq", 32'(irq), 0);

    // R3 boundary: length equal to capacity is sent (single self-linked descriptor)
    build_ring(1, -1, MAXB);
    run_walk(0);
    verify_ring(1, 1);

    // R9: clear
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chkv("R9 irq cleared by irq_clr", 32'(irq), 0);

    // R8: zero-length descriptor in the middle, interrupt disabled
    irq_en = 0;
    build_ring(3, 1, -1);
    run_walk(0);
    verify_ring(3, 0);

    // random rings; odd iterations poke the pointer during the walk (R1)
    for (int it = 0; it < 6; it++) begin
      int n;
      n = 2 + int'($urandom % 7);
      irq_en = 1'($urandom);
      @(negedge clk); irq_clr = 1;
      @(negedge clk); irq_clr = 0;
      build_ring(n, (it == 2) ? n - 1 : -1, -1);
      run_walk(it[0]);
      verify_ring(n, irq_en);
    end

    summary();
  end
endmodule